// File: doc/BRIEF.md
# Saturating Multi-Operation DSP ALU

This unit is the arithmetic stage of a 16-bit DSP datapath. Each cycle it takes two two's-complement operands and a 3-bit operation code. It returns one 16-bit result, registered once at the output. The operations are wrapping add and subtract, clamped add and subtract, the halved sum, the clamped sum of magnitudes and the clamped magnitude of the difference.

All operations share one adder. It is two bits wider than the operands: one extra bit holds the carry of a 16-bit sum, and a second holds +32768, the magnitude of -32768. Before the adder, a magnitude stage can replace each operand with its absolute value. After it, a conditional negate produces the magnitude of the difference, and a clamp stage bounds the result to the signed 16-bit range.

Top module: `sat_dsp_alu`

## Requirements
- R1: With code 0, the result is A+B modulo 2^16.
- R2: With code 1, the result is A-B modulo 2^16.
- R3: With code 2, the result is A+B clamped to the range -32768..+32767.
- R4: With code 3, the result is A-B clamped to the range -32768..+32767.
- R5: With code 4, the result is the exact 17-bit sum A+B shifted right arithmetically by one, so it rounds toward minus infinity and never overflows.
- R6: With code 5, the result is |A|+|B| clamped to +32767. |-32768| counts as +32768.
- R7: With code 6, the result is |A-B| clamped to +32767.
- R8: Code 7 is reserved, and its result is 0.
- R9: The result appears on the first rising clock edge after the operands and code are applied. While rst_n is low, the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code (0..7, see requirements) |
| op_a | input | 16 | Operand A, two's complement |
| op_b | input | 16 | Operand B, two's complement |
| result | output | 16 | Registered result |

## Verification
Every operation has a latency of exactly one clock. An input set applied before rising edge n appears on `result` just after edge n, and it stays there until edge n+1. The driver applies inputs on falling edges and queues the expected value with its requirement tag. The monitor wakes shortly after each rising edge and compares against the oldest queued entry. This keeps each check one register stage behind its stimulus. The expected values come from integer arithmetic in the bench and cover every code with the operands -32768, -1, 0 and 32767, as well as random operands.

// File: rtl/sat_dsp_alu.sv
module sat_dsp_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] result
);
  localparam int EW = W + 2;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_SADD = 3'd2, OP_SSUB = 3'd3,
                         OP_AVG = 3'd4, OP_ABSSUM = 3'd5, OP_ABSDIF = 3'd6, OP_RSV = 3'd7;
  localparam logic signed [EW-1:0] SMAX = EW'((1 << (W-1)) - 1);
  localparam logic signed [EW-1:0] SMIN = -SMAX - EW'(1);

  logic signed [EW-1:0] ax, bx, pa, pb, sum, mag;
  logic                 sub, use_abs;
  logic [W-1:0]         clamped, nxt;

  assign ax      = {{2{op_a[W-1]}}, op_a};
  assign bx      = {{2{op_b[W-1]}}, op_b};
  assign use_abs = (op_sel == OP_ABSSUM);
  assign sub     = (op_sel == OP_SUB) || (op_sel == OP_SSUB) || (op_sel == OP_ABSDIF);

  assign pa  = (use_abs && ax[EW-1]) ? -ax : ax;
  assign pb  = (use_abs && bx[EW-1]) ? -bx : bx;
  assign sum = pa + (sub ? ~pb : pb) + {{(EW-1){1'b0}}, sub};
  assign mag = ((op_sel == OP_ABSDIF) && sum[EW-1]) ? -sum : sum;

  always_comb begin
    if (mag > SMAX)      clamped = SMAX[W-1:0];
    else if (mag < SMIN) clamped = SMIN[W-1:0];
    else                 clamped = mag[W-1:0];
  end

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB: nxt = sum[W-1:0];
      OP_AVG:         nxt = sum[W:1];
      OP_RSV:         nxt = '0;
      default:        nxt = clamped;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else        result <= nxt;
  end

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_SUB_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) == OP_SUB) |-> (W'(result + $past(op_b)) == $past(op_a))); // R2
  AST_SADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) == OP_SADD && !$past(op_a[W-1]) && !$past(op_b[W-1])) |-> !result[W-1]); // R3
  AST_SSUB_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) == OP_SSUB && !$past(op_a[W-1]) && $past(op_b[W-1])) |-> !result[W-1]); // R4
  AST_AVG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) == OP_AVG) |->
      (($signed(result) >= $signed($past(op_a)) || $signed(result) >= $signed($past(op_b))) &&
       ($signed(result) <= $signed($past(op_a)) || $signed(result) <= $signed($past(op_b))))); // R5
  AST_ABSSUM_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) == OP_ABSSUM) |-> !result[W-1]); // R6
  AST_ABSDIF_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) == OP_ABSDIF) |-> !result[W-1]); // R7
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) == OP_RSV) |-> (result == '0)); // R8
endmodule

// File: tb/sat_dsp_alu_test.sv
`timescale 1ns/1ps
module sat_dsp_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [15:0] op_a = 16'd0, op_b = 16'd0;
  logic [15:0] result;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  sat_dsp_alu uut (.clk(clk), .rst_n(rst_n), .op_sel(op_sel), .op_a(op_a), .op_b(op_b), .result(result));

  function automatic logic [15:0] clamp(int v);
    if (v > 32767) return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return 16'(v);
  endfunction

  function automatic int absi(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic logic [15:0] model(logic [2:0] op, logic [15:0] ua, logic [15:0] ub);
    int a, b;
    a = int'($signed(ua));
    b = int'($signed(ub));
    case (op)
      3'd0: return 16'(a + b);
      3'd1: return 16'(a - b);
      3'd2: return clamp(a + b);
      3'd3: return clamp(a - b);
      3'd4: return 16'((a + b) >>> 1);
      3'd5: return clamp(absi(a) + absi(b));
      3'd6: return clamp(absi(a - b));
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R5"; 3'd5: return "R6"; 3'd6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] op, logic [15:0] a, logic [15:0] b);
    item_t it;
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b;
    it.exp = model(op, a, b);
    it.tag = tag_of(op);
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(result, it.exp, it.tag);
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] corners [4];
    corners[0] = 16'h8000; corners[1] = 16'hFFFF; corners[2] = 16'h0000; corners[3] = 16'h7FFF;
    op_sel = 3'd2; op_a = 16'h7FFF; op_b = 16'h7FFF;
    repeat (3) @(posedge clk);
    #1 check(result, 16'h0000, "R9 reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          drive(3'(op), corners[i], corners[j]);
    drive(3'd4, 16'hFFFF, 16'h0000);
    drive(3'd4, 16'h0003, 16'h0000);
    drive(3'd6, 16'h8000, 16'h0001);
    drive(3'd5, 16'h8000, 16'h0000);
    for (int k = 0; k < 600; k++)
      drive(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom));
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1 check(result, 16'h0000, "R9 reset mid-run");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule